// File: doc/BRIEF.md
# Triggered Ring/Linear Sample Logger

This block records one record into an external memory for each sampling pulse it accepts. A record is a free-running cycle timestamp placed next to a wide user data word. It is written as a single request at the current record address. A new logging session begins on each rising edge of the enable input. The session start clears the address and the sample counter.

Three storage behaviours are available. Linear storage fills the configured number of records and then halts. Ring storage wraps back to address zero and keeps going. In ring storage an end trigger can also be enabled; it arms a countdown of further samples, and the session halts when the countdown finishes. The memory side is a request/ready pair: a request stays up until the memory accepts it, and any pulse that arrives while a write is still waiting is lost and flagged.

Top module: `rec_logger`

## Requirements
- R1: Each accepted sample produces exactly one memory write. `memData` holds the timestamp in bits [511:432] and the user data in bits [431:0]. `memReq` and the request contents stay unchanged until a cycle in which `memReady` is high.
- R2: The first record of a session goes to address 0, and every further record goes to the previous address plus one.
- R3: A pulse on `samplePulse` is taken only when `logEn` is 1, `runEn` is 1 and `status` is 1. In every other case it writes nothing and leaves the counter unchanged.
- R4: With `cfgRing` = 0, once `bufSize` records have been written, `status` becomes 2 and later pulses write nothing. Logging resumes only after `logEn` goes to 0 and then back to 1.
- R5: With `cfgRing` = 1, the record written after the one at address `bufSize`-1 goes to address 0. Logging continues (`status` 1) until `logEn` is 0.
- R6: With `cfgRing` = 1 and `cfgTrigEn` = 1, an `endTrig` pulse arms a countdown of `{postTrigHi,postTrigLo}` records, counted from the cycle after the trigger. When the last of them is written, `status` becomes 3 and no more records are written.
- R7: `{sampleCntHi,sampleCntLo}` is cleared when a session starts and rises by one for each record taken.
- R8: `status` reads 0 whenever `logEn` has been low for a cycle, 1 while logging, 2 when a linear buffer is full, and 3 after a trigger stop.
- R9: A pulse that arrives while a request is waiting and `memReady` is low is dropped. It sets `overrun`, which stays set until the next session start. The waiting record is the one that gets written.
- R10: An `endTrig` is ignored in linear storage, when `cfgTrigEn` is 0, and when it repeats after the countdown has been armed.
- R11: A post-trigger count of 0 moves `status` to 3 on the trigger edge. It writes no record, even for a pulse that arrives in the same cycle.
- R12: The timestamp rises by one every clock cycle. Two records therefore carry timestamps that differ by the number of cycles between their pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Internal operation started |
| logEn | input | 1 | Logging enable; a rising edge starts a session |
| samplePulse | input | 1 | One-cycle user sampling pulse |
| endTrig | input | 1 | End trigger |
| cfgRing | input | 1 | 0 selects linear storage, 1 selects ring storage |
| cfgTrigEn | input | 1 | Enables the end trigger in ring storage |
| bufSize | input | ADDR_W | Records per buffer (0 means 2^ADDR_W) |
| postTrigLo | input | 16 | Post-trigger sample count, lower half |
| postTrigHi | input | 16 | Post-trigger sample count, upper half |
| userData | input | DATA_W | User data captured with each record |
| memReq | output | 1 | Write request |
| memAddr | output | ADDR_W | Record address of the request |
| memData | output | TS_W+DATA_W | Record contents |
| memReady | input | 1 | Memory accepts the request this cycle |
| status | output | 2 | 0 idle, 1 logging, 2 full, 3 trigger stop |
| sampleCntLo | output | 16 | Sample counter, lower half |
| sampleCntHi | output | 16 | Sample counter, upper half |
| overrun | output | 1 | Sticky flag for a dropped pulse |

## Verification
The hardest state to reach is a pulse that lands while the previous write is still waiting for the memory. The bench gets there by holding `memReady` low across two pulses. It then checks that the flag is set, that the counter moved only once, and that the first record, not the second, reaches the memory model once ready returns. A second hard case is a trigger repeated during the countdown and a zero-length countdown whose trigger arrives together with a pulse. Both are driven in a single cycle from the bench tasks, and the bench checks the exact record count at which the stop happens.

// File: rtl/rec_logger_pkg.sv
package rec_logger_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOG  = 2'd1,
    ST_FULL = 2'd2,
    ST_TRIG = 2'd3
  } logState_t;

  typedef struct packed {
    logic startSess;
    logic capture;
    logic overrunSet;
  } dpCtrl_t;

endpackage

// File: rtl/rec_logger_ctrl.sv
module rec_logger_ctrl
  import rec_logger_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             logEn,
  input  logic             samplePulse,
  input  logic             endTrig,
  input  logic             cfgRing,
  input  logic             cfgTrigEn,
  input  logic [CNT_W-1:0] postTrig,
  input  logic             lastSlot,
  input  logic             busy,
  output dpCtrl_t          ctrl,
  output logState_t        state
);

  logic             logEnPrev;
  logic             trigArmed;
  logic [CNT_W-1:0] remain;
  logic             startEdge;
  logic             eligible;
  logic             trigHit;
  logic             zeroStop;
  logic             lastPost;

  assign startEdge = logEn & ~logEnPrev;
  assign eligible  = (state == ST_LOG) & logEn & runEn & samplePulse;
  assign trigHit   = (state == ST_LOG) & logEn & cfgRing & cfgTrigEn & endTrig & ~trigArmed;
  assign zeroStop  = trigHit & (postTrig == '0);
  assign lastPost  = trigArmed & (remain == CNT_W'(1));

  always_comb begin
    ctrl            = '0;
    ctrl.startSess  = startEdge;
    ctrl.capture    = eligible & ~busy & ~zeroStop;
    ctrl.overrunSet = eligible & busy & ~zeroStop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logEnPrev <= 1'b0;
    end else begin
      logEnPrev <= logEn;
    end
  end

  // post-trigger countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigArmed <= 1'b0;
      remain    <= '0;
    end else if (startEdge || !logEn) begin
      trigArmed <= 1'b0;
      remain    <= '0;
    end else if (trigHit) begin
      trigArmed <= 1'b1;
      remain    <= postTrig;
    end else if (ctrl.capture && trigArmed && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (!logEn) begin
      state <= ST_IDLE;
    end else if (startEdge) begin
      state <= ST_LOG;
    end else if (state == ST_LOG) begin
      if (zeroStop) begin
        state <= ST_TRIG;
      end else if (ctrl.capture && lastPost) begin
        state <= ST_TRIG;
      end else if (ctrl.capture && lastSlot && !cfgRing) begin
        state <= ST_FULL;
      end
    end
  end

endmodule

// File: rtl/rec_logger_dp.sv
module rec_logger_dp
  import rec_logger_pkg::*;
#(
  parameter int TS_W   = 80,
  parameter int DATA_W = 432,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctrl,
  input  logic [DATA_W-1:0]      userData,
  input  logic [ADDR_W-1:0]      bufSize,
  input  logic                   memReady,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [TS_W+DATA_W-1:0] memData,
  output logic                   lastSlot,
  output logic                   busy,
  output logic [CNT_W-1:0]       sampleCnt,
  output logic                   overrun
);

  localparam int REC_W = TS_W + DATA_W;

  logic [TS_W-1:0]   tsCnt;
  logic [ADDR_W-1:0] recAddr;

  assign lastSlot = (recAddr == bufSize - 1'b1);
  assign busy     = memReq & ~memReady;

  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.startSess) begin
      recAddr <= '0;
    end else if (ctrl.capture) begin
      recAddr <= lastSlot ? '0 : recAddr + 1'b1;
    end
  end

  // request register held until accepted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq  <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else if (ctrl.capture) begin
      memReq  <= 1'b1;
      memAddr <= recAddr;
      memData <= REC_W'({tsCnt, userData});
    end else if (memReady) begin
      memReq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.startSess) begin
      sampleCnt <= '0;
    end else if (ctrl.capture) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.startSess) begin
      overrun <= 1'b0;
    end else if (ctrl.overrunSet) begin
      overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/rec_logger.sv
module rec_logger
  import rec_logger_pkg::*;
#(
  parameter int TS_W   = 80,
  parameter int DATA_W = 432,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   runEn,
  input  logic                   logEn,
  input  logic                   samplePulse,
  input  logic                   endTrig,
  input  logic                   cfgRing,
  input  logic                   cfgTrigEn,
  input  logic [ADDR_W-1:0]      bufSize,
  input  logic [CNT_W/2-1:0]     postTrigLo,
  input  logic [CNT_W/2-1:0]     postTrigHi,
  input  logic [DATA_W-1:0]      userData,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [TS_W+DATA_W-1:0] memData,
  input  logic                   memReady,
  output logic [1:0]             status,
  output logic [CNT_W/2-1:0]     sampleCntLo,
  output logic [CNT_W/2-1:0]     sampleCntHi,
  output logic                   overrun
);

  localparam int HALF = CNT_W / 2;

  dpCtrl_t          ctrl;
  logState_t        state;
  logic             lastSlot;
  logic             busy;
  logic [CNT_W-1:0] sampleCnt;

  rec_logger_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .logEn      (logEn),
    .samplePulse(samplePulse),
    .endTrig    (endTrig),
    .cfgRing    (cfgRing),
    .cfgTrigEn  (cfgTrigEn),
    .postTrig   ({postTrigHi, postTrigLo}),
    .lastSlot   (lastSlot),
    .busy       (busy),
    .ctrl       (ctrl),
    .state      (state)
  );

  rec_logger_dp #(
    .TS_W(TS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .userData (userData),
    .bufSize  (bufSize),
    .memReady (memReady),
    .memReq   (memReq),
    .memAddr  (memAddr),
    .memData  (memData),
    .lastSlot (lastSlot),
    .busy     (busy),
    .sampleCnt(sampleCnt),
    .overrun  (overrun)
  );

  assign status      = state;
  assign sampleCntLo = sampleCnt[HALF-1:0];
  assign sampleCntHi = sampleCnt[CNT_W-1:HALF];

endmodule

// File: rtl/rec_logger_chk.sv
module rec_logger_chk #(
  parameter int ADDR_W = 16,
  parameter int REC_W  = 512,
  parameter int HALF   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              logEn,
  input logic              memReq,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [REC_W-1:0]  memData,
  input logic [1:0]        status,
  input logic [HALF-1:0]   sampleCntLo,
  input logic [HALF-1:0]   sampleCntHi,
  input logic              overrun
);

  logic [2*HALF-1:0] cnt;
  assign cnt = {sampleCntHi, sampleCntLo};

  // R1 / R9: a waiting request keeps its contents
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memData));

  // R8: disabled logging reads idle
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !logEn |=> status == 2'd0);

  // R7: counter moves by one or clears
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    cnt != $past(cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

  // R4: no new request once full
  a_r4_full_no_write: assert property (@(posedge clk) disable iff (!rstN)
    status == 2'd2 |=> !$rose(memReq));

  // R6: no new request after trigger stop
  a_r6_trig_no_write: assert property (@(posedge clk) disable iff (!rstN)
    status == 2'd3 |=> !$rose(memReq));

  // R9: overrun clears only at a session start
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(logEn));

endmodule

bind rec_logger rec_logger_chk #(
  .ADDR_W(ADDR_W), .REC_W(TS_W + DATA_W), .HALF(CNT_W / 2)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .logEn      (logEn),
  .memReq     (memReq),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .memData    (memData),
  .status     (status),
  .sampleCntLo(sampleCntLo),
  .sampleCntHi(sampleCntHi),
  .overrun    (overrun)
);

// File: tb/sim_rec_logger.sv
module sim_rec_logger;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W   = 80;
  localparam int DATA_W = 432;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 32;
  localparam int LOG_N  = 256;
  localparam int GAP    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, logEn = 1'b0, samplePulse = 1'b0, endTrig = 1'b0;
  logic cfgRing = 1'b0, cfgTrigEn = 1'b0, memReady = 1'b1;
  logic [ADDR_W-1:0] bufSize = 16'd4;
  logic [15:0] postTrigLo = '0, postTrigHi = '0;
  logic [DATA_W-1:0] userData = '0;
  logic memReq, overrun;
  logic [ADDR_W-1:0] memAddr;
  logic [TS_W+DATA_W-1:0] memData;
  logic [1:0] status;
  logic [15:0] sampleCntLo, sampleCntHi;

  int testCnt = 0;
  int failCnt = 0;
  int wrCount = 0;
  logic [ADDR_W-1:0] logAddr [LOG_N];
  logic [TS_W-1:0]   logTs   [LOG_N];
  logic [31:0]       logTag  [LOG_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rec_logger u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .logEn(logEn),
    .samplePulse(samplePulse), .endTrig(endTrig), .cfgRing(cfgRing),
    .cfgTrigEn(cfgTrigEn), .bufSize(bufSize), .postTrigLo(postTrigLo),
    .postTrigHi(postTrigHi), .userData(userData), .memReq(memReq),
    .memAddr(memAddr), .memData(memData), .memReady(memReady),
    .status(status), .sampleCntLo(sampleCntLo), .sampleCntHi(sampleCntHi),
    .overrun(overrun)
  );

  // behavioural memory: logs each accepted write
  always @(posedge clk) begin
    if (rstN && memReq && memReady) begin
      if (wrCount < LOG_N) begin
        logAddr[wrCount] <= memAddr;
        logTs[wrCount]   <= memData[TS_W+DATA_W-1:DATA_W];
        logTag[wrCount]  <= memData[31:0];
      end
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint cnt32();
    return longint'({sampleCntHi, sampleCntLo});
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] tag);
    @(negedge clk);
    userData = '0;
    userData[31:0] = tag;
    samplePulse = 1'b1;
    @(negedge clk);
    samplePulse = 1'b0;
    tick(GAP - 2);
  endtask

  task automatic trig();
    @(negedge clk);
    endTrig = 1'b1;
    @(negedge clk);
    endTrig = 1'b0;
  endtask

  task automatic startSession();
    @(negedge clk);
    logEn = 1'b0;
    tick(2);
    logEn = 1'b1;
    tick(2);
  endtask

  task automatic testReset();
    chk("R8 reset status", status, 0);
    chk("R1 reset memReq", memReq, 0);
    chk("R7 reset count", cnt32(), 0);
    chk("R9 reset overrun", overrun, 0);
  endtask

  task automatic testLinear();
    int w0;
    cfgRing = 0; cfgTrigEn = 0; bufSize = 4; runEn = 1;
    startSession();
    chk("R8 logging status", status, 1);
    w0 = wrCount;
    for (int i = 0; i < 4; i++) pulse(32'd100 + 32'(i));
    chk("R4 writes until full", wrCount - w0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R2 linear address", logAddr[w0+i], i);
      chk("R1 record data", logTag[w0+i], 100 + i);
    end
    chk("R12 timestamp spacing", longint'(logTs[w0+1] - logTs[w0]), GAP);
    chk("R12 timestamp spacing", longint'(logTs[w0+3] - logTs[w0+2]), GAP);
    chk("R4 full status", status, 2);
    chk("R7 count at full", cnt32(), 4);
    pulse(32'd104);
    pulse(32'd105);
    chk("R4 pulses ignored when full", wrCount - w0, 4);
    chk("R4 still full", status, 2);
    startSession();
    chk("R8 restart status", status, 1);
    chk("R7 count cleared", cnt32(), 0);
    w0 = wrCount;
    pulse(32'd106);
    chk("R2 restart address", logAddr[w0], 0);
    chk("R7 count after restart", cnt32(), 1);
  endtask

  task automatic testGate();
    int w0;
    cfgRing = 1; bufSize = 8;
    startSession();
    runEn = 0;
    w0 = wrCount;
    pulse(32'd200);
    chk("R3 runEn low no write", wrCount - w0, 0);
    chk("R3 runEn low no count", cnt32(), 0);
    runEn = 1;
    @(negedge clk);
    logEn = 0;
    tick(2);
    chk("R8 idle after disable", status, 0);
    pulse(32'd201);
    chk("R3 logEn low no write", wrCount - w0, 0);
  endtask

  task automatic testRing();
    int w0;
    cfgRing = 1; cfgTrigEn = 0; bufSize = 3;
    startSession();
    w0 = wrCount;
    for (int i = 0; i < 7; i++) pulse(32'd300 + 32'(i));
    chk("R5 ring writes", wrCount - w0, 7);
    for (int i = 0; i < 7; i++) chk("R5 ring address", logAddr[w0+i], i % 3);
    chk("R5 ring keeps logging", status, 1);
    chk("R7 ring count", cnt32(), 7);
    trig();
    pulse(32'd307);
    chk("R10 trigger disabled ignored", status, 1);
  endtask

  task automatic testTrigger();
    int w0;
    cfgRing = 1; cfgTrigEn = 1; bufSize = 4; postTrigLo = 3; postTrigHi = 0;
    startSession();
    w0 = wrCount;
    pulse(32'd400);
    pulse(32'd401);
    trig();
    pulse(32'd402);
    trig();
    pulse(32'd403);
    chk("R10 retrigger not reloaded", status, 1);
    pulse(32'd404);
    chk("R6 trigger stop status", status, 3);
    chk("R6 records before stop", wrCount - w0, 5);
    chk("R2 wrap within trigger run", logAddr[w0+4], 0);
    pulse(32'd405);
    chk("R6 no write after stop", wrCount - w0, 5);
  endtask

  task automatic testLinearTrig();
    cfgRing = 0; cfgTrigEn = 1; bufSize = 4; postTrigLo = 1; postTrigHi = 0;
    startSession();
    pulse(32'd500);
    trig();
    pulse(32'd501);
    chk("R10 linear trigger ignored", status, 1);
    pulse(32'd502);
    pulse(32'd503);
    chk("R10 linear fills to full", status, 2);
  endtask

  task automatic testZeroPost();
    int w0;
    cfgRing = 1; cfgTrigEn = 1; bufSize = 4; postTrigLo = 0; postTrigHi = 0;
    startSession();
    pulse(32'd600);
    w0 = wrCount;
    @(negedge clk);
    endTrig = 1'b1;
    samplePulse = 1'b1;
    @(negedge clk);
    endTrig = 1'b0;
    samplePulse = 1'b0;
    chk("R11 zero count stops at once", status, 3);
    tick(3);
    chk("R11 no record on zero count", wrCount - w0, 0);
    chk("R11 count unchanged", cnt32(), 1);
  endtask

  task automatic testBackpressure();
    int w0;
    cfgRing = 1; cfgTrigEn = 0; bufSize = 8;
    startSession();
    w0 = wrCount;
    memReady = 0;
    pulse(32'd700);
    chk("R9 request waiting", memReq, 1);
    chk("R9 waiting address", memAddr, 0);
    pulse(32'd701);
    chk("R9 overrun set", overrun, 1);
    chk("R9 dropped pulse not counted", cnt32(), 1);
    chk("R9 nothing written yet", wrCount - w0, 0);
    @(negedge clk);
    memReady = 1;
    tick(3);
    chk("R9 one write after ready", wrCount - w0, 1);
    chk("R9 first record kept", logTag[w0], 700);
    chk("R1 request dropped after accept", memReq, 0);
    chk("R9 overrun sticky", overrun, 1);
    pulse(32'd702);
    chk("R2 next address after held write", logAddr[w0+1], 1);
    startSession();
    chk("R9 overrun cleared on start", overrun, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testLinear();
    testGate();
    testRing();
    testTrigger();
    testLinearTrig();
    testZeroPost();
    testBackpressure();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule